// File: doc/BRIEF.md
# Receive special-character detector with threshold flow requests

This block sits beside a UART receiver. Each time the receiver presents an assembled character, the block passes it unchanged to the receive FIFO write port. When special-character mode is on, it also compares the character with a programmed compare value. The comparison covers only the low 5, 6, 7 or 8 bits selected by the word-length code. A match does not remove the character from the data stream. It sets a sticky status flag, which stays set until the register interface clears it.

The block also produces transmit-side software flow requests from the receive FIFO occupancy. A one-cycle Xoff request is issued when the occupancy rises above the trigger level. A one-cycle Xon request is issued when the occupancy later falls below the trigger level. An occupancy equal to the trigger level leaves the current state as it is.

Top module: `uart_special_char_watch`

## Requirements
- R1: `fifo_push` and `fifo_data` equal `rx_strobe` and `rx_char` in the same cycle, unmodified, including characters that match.
- R2: With `spec_en`=1, `flow_mode`=0 and `word_len`=3, a strobed character equal to `cmp_char` in all 8 bits sets `spec_flag` at the next clock edge.
- R3: `word_len` codes 0, 1, 2 and 3 compare the low 5, 6, 7 and 8 bits respectively. Bit 0 of `cmp_char` pairs with bit 0 of `rx_char`. Bits above the selected length are ignored in both values.
- R4: When `spec_en`=0, no character sets `spec_flag`.
- R5: When any bit of `flow_mode` is 1, no character sets `spec_flag`, even if `spec_en`=1.
- R6: Once set, `spec_flag` stays 1 through non-matching characters. It returns to 0 on the clock edge where `flag_clr`=1 and no match occurs.
- R7: If `flag_clr` and a match occur in the same cycle, `spec_flag` is 1 after that edge.
- R8: When `fifo_level` > `trig_level` and no Xoff is outstanding, `xoff_req` is 1 for exactly one cycle after the next edge. It does not repeat while the level stays above the trigger.
- R9: After an Xoff, `xon_req` pulses for one cycle once `fifo_level` < `trig_level`. A level equal to the trigger produces no request, and no Xon repeats while the level stays low.
- R10: After reset, `spec_flag`, `xoff_req` and `xon_req` are 0 and no Xoff is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_strobe | input | 1 | Received character valid |
| rx_char | input | 8 | Received character |
| word_len | input | 2 | Word-length code (0..3 = 5..8 bits) |
| spec_en | input | 1 | Special-character mode enable |
| flow_mode | input | 4 | Software flow mode bits; nonzero blocks detection |
| cmp_char | input | 8 | Special compare character |
| fifo_level | input | LVL_W | Receive FIFO occupancy |
| trig_level | input | LVL_W | Flow trigger level |
| flag_clr | input | 1 | Read-to-clear strobe for the status flag |
| fifo_push | output | 1 | Receive FIFO write |
| fifo_data | output | 8 | Receive FIFO write data |
| spec_flag | output | 1 | Special character seen |
| xoff_req | output | 1 | One-cycle request to send Xoff |
| xon_req | output | 1 | One-cycle request to send Xon |

## Verification
The assertions assume that the inputs are synchronous to `clk` and that they are settled before each rising edge. They also assume that `fifo_level` and `trig_level` are compared as unsigned values. The stimulus satisfies this by driving every input one time unit after a rising edge and holding it until the next edge. The bench changes the FIFO level only in single steps that cross or touch the trigger, so that every edge-generated request can be observed on its own.

// File: rtl/uart_special_char_watch.sv
module uart_special_char_watch #(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strobe,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [1:0]        word_len,
  input  logic              spec_en,
  input  logic [3:0]        flow_mode,
  input  logic [CHAR_W-1:0] cmp_char,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [LVL_W-1:0]  trig_level,
  input  logic              flag_clr,
  output logic              fifo_push,
  output logic [CHAR_W-1:0] fifo_data,
  output logic              spec_flag,
  output logic              xoff_req,
  output logic              xon_req
);
  localparam int MIN_BITS = CHAR_W - 3;

  logic [CHAR_W-1:0] len_mask;
  logic              active, hit, above, below, paused;

  always_comb begin
    len_mask = '0;
    for (int i = 0; i < CHAR_W; i++)
      len_mask[i] = (i < MIN_BITS + int'(word_len));
  end

  assign fifo_push = rx_strobe;
  assign fifo_data = rx_char;
  assign active    = spec_en && (flow_mode == 4'd0);
  assign hit       = rx_strobe && active && ((rx_char & len_mask) == (cmp_char & len_mask));
  assign above     = fifo_level > trig_level;
  assign below     = fifo_level < trig_level;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        spec_flag <= 1'b0;
    else if (hit)      spec_flag <= 1'b1;
    else if (flag_clr) spec_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      paused   <= 1'b0;
      xoff_req <= 1'b0;
      xon_req  <= 1'b0;
    end else begin
      xoff_req <= !paused && above;
      xon_req  <= paused && below;
      if (!paused && above)     paused <= 1'b1;
      else if (paused && below) paused <= 1'b0;
    end

  // R2
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) hit |=> spec_flag);
  // R4
  flag_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spec_flag) |-> $past(rx_strobe && spec_en && flow_mode == 4'd0));
  // R6
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr && !hit) |=> !spec_flag);
  // R8
  xoff_single_chk: assert property (@(posedge clk) disable iff (!rst_n) xoff_req |=> !xoff_req);
  // R8
  xoff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(xoff_req) |-> $past(above));
  // R9
  xon_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(xon_req) |-> $past(below));
  // R9
  xon_single_chk: assert property (@(posedge clk) disable iff (!rst_n) xon_req |=> !xon_req);
endmodule

// File: tb/sim_uart_special_char_watch.sv
module sim_uart_special_char_watch;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {rx_char, cmp_char, word_len, expected flag}
  localparam logic [18:0] VEC [NV] = '{
    {8'hA5, 8'hA5, 2'd3, 1'b1},
    {8'hA5, 8'h25, 2'd3, 1'b0},
    {8'hA5, 8'h25, 2'd2, 1'b1},
    {8'hE3, 8'h03, 2'd0, 1'b1},
    {8'hE3, 8'h23, 2'd1, 1'b1},
    {8'h13, 8'h03, 2'd0, 1'b0},
    {8'h5A, 8'h1A, 2'd1, 1'b1},
    {8'h5A, 8'h3A, 2'd1, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic rx_strobe = 0, spec_en = 0, flag_clr = 0;
  logic [7:0] rx_char = 0, cmp_char = 0;
  logic [1:0] word_len = 2'd3;
  logic [3:0] flow_mode = 0;
  logic [4:0] fifo_level = 0, trig_level = 5'd8;
  logic fifo_push, spec_flag, xoff_req, xon_req;
  logic [7:0] fifo_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_special_char_watch u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [7:0] c, input logic clr);
    rx_char = c; rx_strobe = 1; flag_clr = clr; #1;
    chk("R1 push", fifo_push, 1);
    chk("R1 data", fifo_data, c);
    tick();
    rx_strobe = 0; flag_clr = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R10 flag", spec_flag, 0);
    chk("R10 xoff", xoff_req, 0);
    chk("R10 xon", xon_req, 0);
    rst_n = 1; tick();
    chk("R10 xoff after release", xoff_req, 0);

    spec_en = 1;
    for (int i = 0; i < NV; i++) begin
      clear_flag();
      cmp_char = VEC[i][10:3]; word_len = VEC[i][2:1];
      send(VEC[i][18:11], 1'b0);
      chk($sformatf("R3 R2 vector %0d", i), spec_flag, VEC[i][0]);
    end

    // R4 disabled mode
    clear_flag(); word_len = 3; cmp_char = 8'h11; spec_en = 0;
    send(8'h11, 0);
    chk("R4 disabled", spec_flag, 0);
    // R5 flow mode bits block detection
    spec_en = 1;
    for (int b = 0; b < 4; b++) begin
      flow_mode = 4'(1 << b);
      send(8'h11, 0);
      chk("R5 flow bit set", spec_flag, 0);
    end
    flow_mode = 0;
    // R6 sticky then clear
    send(8'h11, 0);
    chk("R2 match", spec_flag, 1);
    send(8'h22, 0);
    chk("R6 sticky", spec_flag, 1);
    clear_flag();
    chk("R6 cleared", spec_flag, 0);
    // R7 clear and match together
    send(8'h11, 1);
    chk("R7 match wins", spec_flag, 1);

    // R8 / R9 flow requests
    fifo_level = 5'd3; tick();
    chk("R8 below no xoff", xoff_req, 0);
    fifo_level = 5'd9; tick();
    chk("R8 xoff pulse", xoff_req, 1);
    tick();
    chk("R8 xoff single", xoff_req, 0);
    tick();
    chk("R8 no repeat", xoff_req, 0);
    fifo_level = 5'd8; tick();
    chk("R9 equal no xon", xon_req, 0);
    fifo_level = 5'd7; tick();
    chk("R9 xon pulse", xon_req, 1);
    tick();
    chk("R9 xon single", xon_req, 0);
    chk("R9 no xoff", xoff_req, 0);
    fifo_level = 5'd8; tick(); tick();
    chk("R9 equal after xon", xoff_req + xon_req, 0);
    fifo_level = 5'd10; tick();
    chk("R8 second xoff", xoff_req, 1);

    // R10 reset mid-run
    rst_n = 0; #1;
    chk("R10 async flag", spec_flag, 0);
    chk("R10 async xoff", xoff_req, 0);
    rst_n = 1; fifo_level = 5'd2; tick();
    chk("R10 not paused", xon_req, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule